// File: doc/BRIEF.md
# Disk Channel Interrupt and Bus-Error Status Unit

This unit collects the two interrupt causes of a disk channel: the interrupt request raised by the attached drive and a bus error seen by the channel's DMA engine. Each cause is held in a status register whose bits the host clears by writing ones. An enable mask gates the held causes into a single registered interrupt output. Software changes the mask through two separate ports, one that sets enable bits and one that clears them, so that no read-modify-write is needed.

When a bus error is recorded, the unit also stores the memory address that failed, split into a low and a high word. The stored address stays fixed until software acknowledges the error. The unit also forwards reads of the drive's status byte. A read of that byte while the drive is not busy acknowledges a pending drive interrupt as a side effect.

Top module: `isu_top`

## Requirements
- R1: After reset the cause register, the enable mask, the stored error address and `irq_o` are all zero.
- R2: The cause register sits at word index 3. Bit 0 is the drive interrupt and bit 1 is the bus error. A one-cycle pulse on `drv_irq_i` or `bus_err_i` sets its bit on the next clock edge.
- R3: Writing to word index 3 clears each cause bit whose data bit is 1 and leaves the others unchanged, so writing 0x03 clears both and writing 0 changes nothing.
- R4: If a cause event and a clear of the same bit happen in the same cycle, the event wins and the bit stays set.
- R5: Writing to word index 5 sets the enable bits given as ones, and writing to word index 7 clears them. Reading either index returns the mask in bits [1:0].
- R6: `irq_o` is high one cycle after the cause register ANDed with the mask becomes non-zero, and low one cycle after that value becomes zero.
- R7: A bus error that arrives while cause bit 1 is clear stores its address. The low 32 bits read at word index 0 and the high 32 bits at word index 1.
- R8: While cause bit 1 is set, further bus errors leave the stored address unchanged.
- R9: A read of word index 8 returns `drv_stat_i` in bits [7:0]. If bit 7 (busy) of that byte is 0, the read also clears cause bit 0. If bit 7 is 1, cause bit 0 is kept.
- R10: Read data appears on `rdata_o`, with `rvalid_o` high, in the cycle after the read strobe. Unmapped indices read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| idx_i | input | 4 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| drv_irq_i | input | 1 | Drive interrupt event |
| bus_err_i | input | 1 | DMA bus-error event |
| err_addr_i | input | 64 | Address of the failing DMA access |
| drv_stat_i | input | 8 | Drive status byte |
| irq_o | output | 1 | Interrupt output |

## Verification
Cause and mask updates take effect at the clock edge that samples the strobe or event, so they are visible to a read issued in the following cycle. Read data arrives one cycle after the read strobe, and the scoreboard monitor compares it only in cycles where `rvalid_o` is high. The interrupt output adds one more register stage, so the bench checks `irq_o` two cycles after the stimulus that should change it.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ERRADDR_W = 64;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned NSRC      = 2;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BUSY_BIT  = 7;

  localparam logic [IDX_W-1:0] IDX_ADDR_LO = 4'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR_HI = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CAUSE   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_EN_SET  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_EN_CLR  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_DSTAT   = 4'd8;

  localparam int unsigned SRC_DRIVE = 0;
  localparam int unsigned SRC_BUSERR = 1;
endpackage

// File: rtl/isu_cause_bank.sv
module isu_cause_bank
  import isu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] event_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] en_set_i,
  input  logic [NSRC-1:0] en_clr_i,
  output logic [NSRC-1:0] cause_o,
  output logic [NSRC-1:0] en_o,
  output logic            irq_o
);
  logic [NSRC-1:0] cause_q, cause_d;
  logic [NSRC-1:0] en_q, en_d;
  logic            irq_q, irq_d;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_comb begin
      cause_d[g] = event_i[g] | (cause_q[g] & ~clr_i[g]);
      en_d[g]    = en_set_i[g] | (en_q[g] & ~en_clr_i[g]);
    end
  end

  always_comb irq_d = |(cause_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      en_q    <= en_d;
      irq_q   <= irq_d;
    end
  end

  assign cause_o = cause_q;
  assign en_o    = en_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/isu_err_capture.sv
module isu_err_capture
  import isu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_i,
  input  logic                 held_i,
  input  logic [ERRADDR_W-1:0] addr_i,
  output logic [ERRADDR_W-1:0] addr_o
);
  logic [ERRADDR_W-1:0] addr_q, addr_d;
  logic                 load;

  always_comb begin
    load   = err_i & ~held_i;
    addr_d = load ? addr_i : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/isu_read_mux.sv
module isu_read_mux
  import isu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [ERRADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]      cause_i,
  input  logic [NSRC-1:0]      en_i,
  input  logic [STAT_W-1:0]    dstat_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rvalid_o
);
  localparam int unsigned HALF = ERRADDR_W / 2;
  logic [DATA_W-1:0] sel, rdata_q, rdata_d;
  logic              rvalid_q;

  always_comb begin
    sel = '0;
    case (idx_i)
      IDX_ADDR_LO:            sel = DATA_W'(addr_i[HALF-1:0]);
      IDX_ADDR_HI:            sel = DATA_W'(addr_i[ERRADDR_W-1:HALF]);
      IDX_CAUSE:              sel = DATA_W'(cause_i);
      IDX_EN_SET, IDX_EN_CLR: sel = DATA_W'(en_i);
      IDX_DSTAT:              sel = DATA_W'(dstat_i);
      default:                sel = '0;
    endcase
    rdata_d = rd_i ? sel : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rvalid_o,
  input  logic                 drv_irq_i,
  input  logic                 bus_err_i,
  input  logic [ERRADDR_W-1:0] err_addr_i,
  input  logic [STAT_W-1:0]    drv_stat_i,
  output logic                 irq_o
);
  logic [1:0]           rst_sync_q;
  logic                 rst_n_int;
  logic [NSRC-1:0]      events, cause_clr, en_set, en_clr, cause_q, en_q;
  logic [ERRADDR_W-1:0] err_addr_q;
  logic                 dstat_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    events                = '0;
    events[SRC_DRIVE]     = drv_irq_i;
    events[SRC_BUSERR]    = bus_err_i;
    dstat_ack             = rd_i & (idx_i == IDX_DSTAT) & ~drv_stat_i[BUSY_BIT];
    cause_clr             = (wr_i && idx_i == IDX_CAUSE) ? wdata_i[NSRC-1:0] : '0;
    cause_clr[SRC_DRIVE]  = cause_clr[SRC_DRIVE] | dstat_ack;
    en_set                = (wr_i && idx_i == IDX_EN_SET) ? wdata_i[NSRC-1:0] : '0;
    en_clr                = (wr_i && idx_i == IDX_EN_CLR) ? wdata_i[NSRC-1:0] : '0;
  end

  isu_cause_bank u_bank (
    .clk(clk), .rst_n(rst_n_int), .event_i(events), .clr_i(cause_clr),
    .en_set_i(en_set), .en_clr_i(en_clr), .cause_o(cause_q), .en_o(en_q),
    .irq_o(irq_o)
  );

  isu_err_capture u_cap (
    .clk(clk), .rst_n(rst_n_int), .err_i(bus_err_i),
    .held_i(cause_q[SRC_BUSERR]), .addr_i(err_addr_i), .addr_o(err_addr_q)
  );

  isu_read_mux u_rd (
    .clk(clk), .rst_n(rst_n_int), .rd_i(rd_i), .idx_i(idx_i),
    .addr_i(err_addr_q), .cause_i(cause_q), .en_i(en_q), .dstat_i(drv_stat_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );
endmodule

// File: rtl/isu_checker.sv
module isu_checker
  import isu_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n_int,
  input logic                 drv_irq_i,
  input logic                 bus_err_i,
  input logic                 wr_i,
  input logic [IDX_W-1:0]     idx_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [NSRC-1:0]      cause_q,
  input logic [NSRC-1:0]      en_q,
  input logic [ERRADDR_W-1:0] err_addr_q,
  input logic                 irq_o
);
  AST_DRIVE_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n_int)
    drv_irq_i |=> cause_q[SRC_DRIVE]); // R4
  AST_BUSERR_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_err_i |=> cause_q[SRC_BUSERR]); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n_int)
    cause_q[SRC_BUSERR] |=> $stable(err_addr_q)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((cause_q & en_q) == '0) |=> !irq_o); // R6
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_i && idx_i == IDX_EN_SET && wdata_i[0]) |=> en_q[0]); // R5
  AST_CAUSE_STAYS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cause_q[SRC_BUSERR] && !(wr_i && idx_i == IDX_CAUSE && wdata_i[SRC_BUSERR]))
      |=> cause_q[SRC_BUSERR]); // R3
endmodule

bind isu_top isu_checker u_chk (
  .clk(clk), .rst_n_int(rst_n_int), .drv_irq_i(drv_irq_i), .bus_err_i(bus_err_i),
  .wr_i(wr_i), .idx_i(idx_i), .wdata_i(wdata_i), .cause_q(cause_q), .en_q(en_q),
  .err_addr_q(err_addr_q), .irq_o(irq_o)
);

// File: tb/test_isu_top.sv
module test_isu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [3:0]  idx_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic        drv_irq_i = 1'b0, bus_err_i = 1'b0;
  logic [63:0] err_addr_i = '0;
  logic [7:0]  drv_stat_i = '0;
  logic        irq_o;

  int vectors = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  isu_top i_isu_top (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rvalid_o) begin
      if (exp_q.size() == 0) check("R10 unexpected read", rdata_o, 32'hx);
      else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); wr_i = 1'b1; idx_i = idx; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_i = 1'b1; idx_i = idx; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic pulse_drv();
    @(negedge clk); drv_irq_i = 1'b1;
    @(negedge clk); drv_irq_i = 1'b0;
  endtask

  task automatic pulse_err(input logic [63:0] a);
    @(negedge clk); bus_err_i = 1'b1; err_addr_i = a;
    @(negedge clk); bus_err_i = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); check(tag, {31'b0, irq_o}, {31'b0, exp});
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", {31'b0, irq_o}, 32'd0);
    rd(4'd3, 32'd0, "R1 cause reset");
    rd(4'd5, 32'd0, "R1 mask reset");
    rd(4'd0, 32'd0, "R1 addr reset");
    rd(4'd2, 32'd0, "R10 unmapped index");

    wr(4'd5, 32'h3);
    rd(4'd7, 32'h3, "R5 mask set readback");
    pulse_drv();
    chk_irq(1'b1, "R6 irq on drive event");
    rd(4'd3, 32'h1, "R2 drive bit");
    wr(4'd3, 32'h0);
    rd(4'd3, 32'h1, "R3 write zero no effect");
    wr(4'd3, 32'h1);
    chk_irq(1'b0, "R6 irq drops after clear");
    rd(4'd3, 32'h0, "R3 drive bit cleared");

    pulse_err(64'h1234_5678_9ABC_DEF0);
    rd(4'd3, 32'h2, "R2 bus error bit");
    rd(4'd0, 32'h9ABC_DEF0, "R7 low address");
    rd(4'd1, 32'h1234_5678, "R7 high address");
    pulse_err(64'hAAAA_BBBB_CCCC_DDDD);
    rd(4'd0, 32'h9ABC_DEF0, "R8 low address held");
    rd(4'd1, 32'h1234_5678, "R8 high address held");
    wr(4'd3, 32'h3);
    rd(4'd3, 32'h0, "R3 both cleared");
    pulse_err(64'h0000_0001_0000_0002);
    rd(4'd0, 32'h0000_0002, "R7 recapture after ack");
    wr(4'd3, 32'h2);

    @(negedge clk); wr_i = 1'b1; idx_i = 4'd3; wdata_i = 32'h1; drv_irq_i = 1'b1;
    @(negedge clk); wr_i = 1'b0; drv_irq_i = 1'b0;
    rd(4'd3, 32'h1, "R4 event beats clear");

    wr(4'd7, 32'h1);
    rd(4'd5, 32'h2, "R5 mask clear readback");
    chk_irq(1'b0, "R6 masked drive bit");
    pulse_err(64'h5);
    chk_irq(1'b1, "R6 enabled bus error");
    wr(4'd3, 32'h2);

    drv_stat_i = 8'hD0;
    rd(4'd8, 32'hD0, "R9 status passthrough busy");
    rd(4'd3, 32'h1, "R9 busy keeps drive bit");
    drv_stat_i = 8'h50;
    rd(4'd8, 32'h50, "R9 status passthrough idle");
    rd(4'd3, 32'h0, "R9 idle read clears drive bit");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R10 missing read data", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule